// File: doc/BRIEF.md
# Chainable Serial Register Slave

This block is the device side of a four-wire serial host port. It gives an external controller access to a small bank of 16-bit registers over chip select (active low), serial clock, serial data in and serial data out. Every access opens with a 16-bit command word. The command word carries a direction flag, an auto-increment flag and a register address. One or more 16-bit data words follow the command word.

Write traffic, including the command word, is copied straight from the data input to the data output. Several devices can therefore be wired in a chain, and every device whose chip select is low takes the same write. On a read, the addressed register is fetched when the command word completes. It is then shifted out most significant bit first, with a new bit launched on each falling serial clock edge. The serial pins are brought into the core clock domain through two-flop synchronizers, and the clock edges are detected there.

With auto-increment set, further data words go to consecutive addresses without a new command word. Without it, the word after a data word is taken as a fresh command word.

Top module: `chain_reg_slave`

## Requirements
- R1: Words are 16 bits, received most significant bit first, with one bit taken at each rising serial clock edge while chip select is low. Clock edges while chip select is high are ignored.
- R2: In the command word, bit 15 set means read and bit 15 clear means write. Bit 12 is the auto-increment flag and bits 11:0 hold the register address. Bits 14:13 have no effect.
- R3: On a write, the data word that follows the command word is stored in the addressed register.
- R4: While the block is not shifting read data, sdout equals sdin. This covers the command word and all write data words.
- R5: On a read, sdout shows bit 15 of the addressed register before the first rising edge of the data word. Each later falling edge moves sdout to the next lower bit.
- R6: With auto-increment set, each further data word, for reads and writes alike, uses the previous address plus one.
- R7: With auto-increment clear, the word after a data word is decoded as a new command word.
- R8: Raising chip select discards any partly received word, resets the bit position and clears auto-increment. This holds even when chip select rises in the same synchronized cycle as the rising edge that would complete a word; in that case nothing is written.
- R9: Addresses at or above the register count are not aliased. Writes to them change nothing, and reads from them return zero.
- R10: After reset all registers read zero and sdout equals sdin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdin | input | 1 | Serial data from the host or the previous device |
| sdout | output | 1 | Serial data to the host or the next device |

## Verification
Two functions can fall in the same synchronized core cycle: the rising edge that completes a data word and the chip select deassertion that aborts the access. The bench provokes this by raising csN and sclk at the same instant on the pins. Both pins pass through synchronizers of equal depth, so the completion and the abort reach the control in one cycle. The outcome is judged by reading the target register back in a later access and requiring its earlier value.

// File: rtl/crs_pkg.sv
package crs_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 12;
  localparam int RW_BIT = 15;
  localparam int AI_BIT = 12;

  typedef enum logic [1:0] {
    ST_CMD = 2'd0,
    ST_WR  = 2'd1,
    ST_RD  = 2'd2
  } crsState_t;

  typedef struct packed {
    logic              shiftEn;
    logic              writeReg;
    logic              loadOut;
    logic              readMode;
    logic [ADDR_W-1:0] wrAddr;
    logic [ADDR_W-1:0] rdAddr;
  } crsCtl_t;
endpackage

// File: rtl/crs_datapath.sv
module crs_datapath
  import crs_pkg::*;
#(
  parameter int REG_COUNT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdin,
  input  crsCtl_t           ctl,
  output logic              sclkRise,
  output logic              csActive,
  output logic [WORD_W-1:0] nextWord,
  output logic              sdout
);
  localparam int IDX_W = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;

  logic [1:0] csSync;
  logic [1:0] sdinSync;
  logic [2:0] sclkSync;
  logic       sclkFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync   <= 2'b11;
      sdinSync <= 2'b00;
      sclkSync <= 3'b000;
    end else begin
      csSync   <= {csSync[0], csN};
      sdinSync <= {sdinSync[0], sdin};
      sclkSync <= {sclkSync[1:0], sclk};
    end
  end

  assign csActive = !csSync[1];
  assign sclkRise = sclkSync[1] && !sclkSync[2];
  assign sclkFall = !sclkSync[1] && sclkSync[2];

  // receive shifter
  logic [WORD_W-1:0] shiftIn;
  assign nextWord = {shiftIn[WORD_W-2:0], sdinSync[1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shiftIn <= '0;
    else if (!csActive)    shiftIn <= '0;
    else if (ctl.shiftEn)  shiftIn <= nextWord;
  end

  // register bank
  logic [REG_COUNT-1:0][WORD_W-1:0] regs;
  logic [REG_COUNT-1:0]             wrHit;

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_hit
    assign wrHit[g] = ctl.writeReg && (ctl.wrAddr == ADDR_W'(g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regs <= '0;
    end else begin
      for (int i = 0; i < REG_COUNT; i++)
        if (wrHit[i]) regs[i] <= nextWord;
    end
  end

  logic              rdHit;
  logic [WORD_W-1:0] rdData;
  assign rdHit  = ctl.rdAddr < ADDR_W'(REG_COUNT);
  assign rdData = rdHit ? regs[ctl.rdAddr[IDX_W-1:0]] : '0;

  // transmit shifter
  logic [WORD_W-1:0] outShift;
  logic              holdFirst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outShift  <= '0;
      holdFirst <= 1'b0;
    end else if (!csActive) begin
      outShift  <= '0;
      holdFirst <= 1'b0;
    end else if (ctl.loadOut) begin
      outShift  <= rdData;
      holdFirst <= 1'b1;
    end else if (ctl.readMode && sclkFall) begin
      if (holdFirst) holdFirst <= 1'b0;
      else           outShift  <= {outShift[WORD_W-2:0], 1'b0};
    end
  end

  assign sdout = ctl.readMode ? outShift[WORD_W-1] : sdin;

  // R9
  oob_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.writeReg && ctl.wrAddr >= ADDR_W'(REG_COUNT)) |=> $stable(regs));

  // R3
  bank_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.writeReg |=> $stable(regs));

  // R5
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csActive && !ctl.loadOut && !sclkFall) |=> $stable(outShift));
endmodule

// File: rtl/crs_control.sv
module crs_control
  import crs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkRise,
  input  logic              csActive,
  input  logic [WORD_W-1:0] nextWord,
  output crsCtl_t           ctl
);
  localparam int CNT_W = $clog2(WORD_W);

  crsState_t         state;
  logic [CNT_W-1:0]  bitCnt;
  logic [ADDR_W-1:0] addr;
  logic              autoInc;
  logic              wordDone;
  logic              isRead;

  assign wordDone = csActive && sclkRise && (bitCnt == CNT_W'(WORD_W - 1));
  assign isRead   = nextWord[RW_BIT];

  always_comb begin
    ctl          = '0;
    ctl.shiftEn  = csActive && sclkRise;
    ctl.readMode = (state == ST_RD);
    ctl.wrAddr   = addr;
    ctl.writeReg = wordDone && (state == ST_WR);
    ctl.loadOut  = wordDone && (((state == ST_CMD) && isRead) ||
                                ((state == ST_RD) && autoInc));
    ctl.rdAddr   = (state == ST_CMD) ? nextWord[ADDR_W-1:0] : addr + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_CMD;
      bitCnt  <= '0;
      addr    <= '0;
      autoInc <= 1'b0;
    end else if (!csActive) begin
      state   <= ST_CMD;
      bitCnt  <= '0;
      autoInc <= 1'b0;
    end else if (sclkRise) begin
      bitCnt <= bitCnt + CNT_W'(1);
      if (wordDone) begin
        if (state == ST_CMD) begin
          addr    <= nextWord[ADDR_W-1:0];
          autoInc <= nextWord[AI_BIT];
          state   <= isRead ? ST_RD : ST_WR;
        end else if (autoInc) begin
          addr <= addr + ADDR_W'(1);
        end else begin
          state <= ST_CMD;
        end
      end
    end
  end

  // R8
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |=> (bitCnt == '0 && !autoInc && state == ST_CMD));

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wordDone && state != ST_CMD && autoInc) |=> (addr == $past(addr) + ADDR_W'(1)));

  // R2
  dir_decode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wordDone && state == ST_CMD) |=>
      (state == ($past(nextWord[RW_BIT]) ? ST_RD : ST_WR)));

  // R7
  back_to_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wordDone && state != ST_CMD && !autoInc) |=> (state == ST_CMD));
endmodule

// File: rtl/chain_reg_slave.sv
module chain_reg_slave
  import crs_pkg::*;
#(
  parameter int REG_COUNT = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sclk,
  input  logic sdin,
  output logic sdout
);
  crsCtl_t           ctl;
  logic              sclkRise;
  logic              csActive;
  logic [WORD_W-1:0] nextWord;

  crs_datapath #(.REG_COUNT(REG_COUNT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .csN      (csN),
    .sclk     (sclk),
    .sdin     (sdin),
    .ctl      (ctl),
    .sclkRise (sclkRise),
    .csActive (csActive),
    .nextWord (nextWord),
    .sdout    (sdout)
  );

  crs_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .sclkRise (sclkRise),
    .csActive (csActive),
    .nextWord (nextWord),
    .ctl      (ctl)
  );
endmodule

// File: tb/sim_chain_reg_slave.sv
module sim_chain_reg_slave;
  localparam int HB = 6;
  localparam int NREG = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic sdin = 1'b0;
  logic sdout;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [15:0] model [NREG];
  logic [15:0] expQ [$];
  string       tagQ [$];
  logic [15:0] rdGot;
  event        rdEv;

  always #4 clk = ~clk;

  chain_reg_slave #(.REG_COUNT(NREG)) u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdin(sdin), .sdout(sdout)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(rdEv);
      if (expQ.size() == 0) begin
        check(1'b0, "R5 unexpected read", rdGot, 16'h0);
      end else begin
        logic [15:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(rdGot === e, t, rdGot, e);
      end
    end
  end

  function automatic logic [15:0] cmdWord(input bit rd, input bit ai, input logic [11:0] a);
    return {rd, 2'b00, ai, a};
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frameOpen();
    csN = 1'b0;
    wait_n(4);
  endtask

  task automatic frameClose();
    wait_n(4);
    csN = 1'b1;
    wait_n(8);
  endtask

  task automatic sendBits(input logic [15:0] w, input int nb, input bit chk,
                          input string tag);
    int bad = 0;
    for (int i = 15; i > 15 - nb; i--) begin
      sdin = w[i];
      wait_n(1);
      if (sdout !== w[i]) bad++;
      wait_n(HB - 1);
      sclk = 1'b1;
      wait_n(HB);
      sclk = 1'b0;
    end
    if (chk) check(bad == 0, tag, 16'(bad), 16'h0);
  endtask

  task automatic sendWord(input logic [15:0] w);
    sendBits(w, 16, 1'b0, "");
  endtask

  task automatic readWord(input logic [15:0] e, input string tag);
    logic [15:0] w;
    for (int i = 15; i >= 0; i--) begin
      sdin = 1'b0;
      wait_n(HB);
      w[i] = sdout;
      sclk = 1'b1;
      wait_n(HB);
      sclk = 1'b0;
    end
    expQ.push_back(e);
    tagQ.push_back(tag);
    rdGot = w;
    ->rdEv;
    wait_n(1);
  endtask

  task automatic regWrite(input logic [11:0] a, input logic [15:0] d);
    frameOpen();
    sendWord(cmdWord(1'b0, 1'b0, a));
    sendWord(d);
    frameClose();
    if (a < NREG) model[a] = d;
  endtask

  task automatic regRead(input logic [11:0] a, input logic [15:0] e, input string tag);
    frameOpen();
    sendWord(cmdWord(1'b1, 1'b0, a));
    readWord(e, tag);
    frameClose();
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = 16'h0;
    wait_n(5);
    rstN = 1'b1;
    wait_n(5);

    // R10 reset state
    sdin = 1'b1; #1;
    check(sdout === 1'b1, "R10 sdout follows sdin high", 16'(sdout), 16'h1);
    sdin = 1'b0; #1;
    check(sdout === 1'b0, "R10 sdout follows sdin low", 16'(sdout), 16'h0);
    regRead(12'd3, 16'h0, "R10 register reset value");

    // R1 clock toggles with chip select high are ignored
    sdin = 1'b1;
    for (int k = 0; k < 5; k++) begin
      sclk = 1'b1; wait_n(HB); sclk = 1'b0; wait_n(HB);
    end

    // R3 / R5 / R1 basic write then read, MSB first
    regWrite(12'd5, 16'hA5C3);
    regRead(12'd5, 16'hA5C3, "R3 R5 R1 write then read reg5");
    regWrite(12'd15, 16'h8001);
    regRead(12'd15, 16'h8001, "R5 edge bits reg15");

    // R4 pass-through during write command and data
    frameOpen();
    sendBits(cmdWord(1'b0, 1'b0, 12'd2), 16, 1'b1, "R4 pass-through on command");
    sendBits(16'h3C96, 16, 1'b1, "R4 pass-through on data");
    frameClose();
    model[2] = 16'h3C96;
    regRead(12'd2, 16'h3C96, "R4 forwarded write also stored");

    // R6 auto-increment write and read
    frameOpen();
    sendWord(cmdWord(1'b0, 1'b1, 12'd7));
    sendWord(16'h1111);
    sendWord(16'h2222);
    sendWord(16'h3333);
    frameClose();
    model[7] = 16'h1111; model[8] = 16'h2222; model[9] = 16'h3333;
    frameOpen();
    sendWord(cmdWord(1'b1, 1'b1, 12'd7));
    readWord(16'h1111, "R6 autoinc read word0");
    readWord(16'h2222, "R6 autoinc read word1");
    readWord(16'h3333, "R6 autoinc read word2");
    frameClose();

    // R7 without auto-increment the next word is a command
    frameOpen();
    sendWord(cmdWord(1'b0, 1'b0, 12'd3));
    sendWord(16'h4444);
    sendWord(cmdWord(1'b0, 1'b0, 12'd10));
    sendWord(16'h5555);
    frameClose();
    model[3] = 16'h4444; model[10] = 16'h5555;
    regRead(12'd3, 16'h4444, "R7 first pair");
    regRead(12'd10, 16'h5555, "R7 second command decoded");
    regRead(12'd4, 16'h0000, "R7 no increment into reg4");

    // R2 reserved bits ignored
    frameOpen();
    sendWord(16'h6001);
    sendWord(16'h0BAD);
    frameClose();
    model[1] = 16'h0BAD;
    regRead(12'd1, 16'h0BAD, "R2 reserved bits ignored");

    // R9 out of range
    regWrite(12'h100, 16'h7777);
    regRead(12'h100, 16'h0000, "R9 out of range reads zero");
    regRead(12'd0, 16'h0000, "R9 no alias into reg0");

    // R8 partial word aborted
    regWrite(12'd4, 16'h1234);
    frameOpen();
    sendWord(cmdWord(1'b0, 1'b0, 12'd4));
    sendBits(16'hFFFF, 8, 1'b0, "");
    frameClose();
    regRead(12'd4, 16'h1234, "R8 partial word discarded");

    // R8 auto-increment cleared by chip select
    frameOpen();
    sendWord(cmdWord(1'b0, 1'b1, 12'd11));
    sendWord(16'hAAAA);
    sendBits(16'h0F0F, 8, 1'b0, "");
    frameClose();
    model[11] = 16'hAAAA;
    frameOpen();
    sendWord(cmdWord(1'b0, 1'b0, 12'd13));
    sendWord(16'hBBBB);
    frameClose();
    model[13] = 16'hBBBB;
    regRead(12'd11, 16'hAAAA, "R8 word before abort kept");
    regRead(12'd12, 16'h0000, "R8 autoinc cleared reg12 untouched");
    regRead(12'd13, 16'hBBBB, "R8 new frame starts with command");

    // R8 chip select rises with the completing edge
    frameOpen();
    sendWord(cmdWord(1'b0, 1'b0, 12'd6));
    sendBits(16'hBEEF, 15, 1'b0, "");
    sdin = 1'b1;
    wait_n(HB);
    sclk = 1'b1;
    csN  = 1'b1;
    wait_n(HB);
    sclk = 1'b0;
    wait_n(8);
    regRead(12'd6, 16'h0000, "R8 coincident abort blocks write");

    wait_n(20);
    check(expQ.size() == 0, "R5 all reads observed", 16'(expQ.size()), 16'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule